// File: doc/BRIEF.md
# Move-Only Pipeline Hazard Unit

This block is the three-stage pipeline of a processor with one instruction: copy a word from one memory address to another. The first stage fetches the instruction, which is a source address word and a destination address word. The second stage reads the operand at the source address. The third stage writes that operand to the destination address. Every stage uses its own memory port on every cycle. Reads return data in the same cycle. Writes take effect at the clock edge that ends the cycle.

A read-after-write hazard occurs when the operand read in stage two targets the address that stage three is writing in the same cycle. That read would return the old contents, so the block resolves the hazard in one of two ways, chosen by address. In ordinary memory, the word being stored is forwarded as the operand. In the top address region, which is reserved for the memory-mapped ALU and devices, a read does not return what was last written. There the read is stalled for one cycle and a bubble enters the store stage, so the read is issued again after the store has completed. Two status outputs show which of the two actions is taken in each cycle.

Top module: `mv_pipe_hazard`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `if_addr0_o` is 0, `if_addr1_o` is 1, and `st_we_o`, `fwd_o` and `ilk_o` are all 0.
- R2: `if_addr1_o` always equals `if_addr0_o + 1`. An instruction is accepted at a clock edge where `if_vld_i` is 1 and `ilk_o` is 0, and the fetch address then advances by 2. In every other case the fetch address holds and no instruction enters the pipeline.
- R3: An instruction accepted at edge n presents its source address on `of_addr_o` in the cycle after edge n. In the cycle after its operand is taken, it drives `st_we_o`=1 with `st_addr_o` set to its destination and `st_wdata_o` set to the operand. Stores appear in program order.
- R4: A hazard exists only when both the operand stage and the store stage hold valid instructions and `of_addr_o == st_addr_o`. Without a hazard, `fwd_o` and `ilk_o` are 0 and the operand is `of_rdata_i`. Two dependent moves separated by at least one bubble therefore have no hazard.
- R5: A hazard on a source address below `DEV_BASE` (default 16'hFF00) raises `fwd_o` for one cycle. The operand is then the value on `st_wdata_o` in that cycle, and no stall occurs.
- R6: A hazard on a source address at or above `DEV_BASE` raises `ilk_o`. In the next cycle `st_we_o` is 0, and `of_addr_o` and `if_addr0_o` are unchanged. The operand is then taken from `of_rdata_i` of that repeated read.
- R7: `fwd_o` and `ilk_o` are never 1 in the same cycle.
- R8: `st_we_o` is 1 only for accepted instructions. Bubbles never write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_addr0_o | output | AW | Fetch address of the source word (program counter) |
| if_addr1_o | output | AW | Fetch address of the destination word |
| if_vld_i | input | 1 | Fetched words are a valid instruction |
| if_word0_i | input | AW | Fetched source address |
| if_word1_i | input | AW | Fetched destination address |
| of_addr_o | output | AW | Operand read address |
| of_rdata_i | input | DW | Operand read data, same cycle |
| st_addr_o | output | AW | Store address |
| st_wdata_o | output | DW | Store data |
| st_we_o | output | 1 | Store enable, applied at the clock edge |
| fwd_o | output | 1 | Store data forwarded to the operand stage this cycle |
| ilk_o | output | 1 | Operand stage stalled, bubble injected this cycle |

## Verification
Independent moves with no shared addresses check plain transport and program order. Chains of moves back to back through ordinary memory separate correct forwarding from stale reads. The same chains through device addresses, where a write adds to an accumulator and a read returns it, separate a correct interlock from forwarding: forwarding would deliver the written word instead of the updated sum. Dependent moves separated by a bubble, near-miss addresses, the two addresses on either side of the region boundary, and idle fetch cycles test that the unit fires only on a real adjacent match and that bubbles never store.

// File: rtl/mvh_pkg.sv
package mvh_pkg;
  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_FWD   = 2'd1,
    HZ_STALL = 2'd2
  } hz_act_e;
endpackage

// File: rtl/mvh_fetch.sv
module mvh_fetch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          vld_i,
  input  logic [AW-1:0] word0_i,
  input  logic [AW-1:0] word1_i,
  output logic [AW-1:0] pc_o,
  output logic          s1_vld_o,
  output logic [AW-1:0] s1_src_o,
  output logic [AW-1:0] s1_dst_o
);
  localparam logic [AW-1:0] PC_STEP = AW'(2);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (!hold_i && vld_i) begin
      pc_q <= pc_q + PC_STEP;
    end
  end

  // stage-1 register holds during an interlock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o <= 1'b0;
      s1_src_o <= '0;
      s1_dst_o <= '0;
    end else if (!hold_i) begin
      s1_vld_o <= vld_i;
      s1_src_o <= word0_i;
      s1_dst_o <= word1_i;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/mvh_hazard.sv
module mvh_hazard
  import mvh_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] DEV_BASE = 16'hFF00
) (
  input  logic          s1_vld_i,
  input  logic [AW-1:0] s1_src_i,
  input  logic          s2_vld_i,
  input  logic [AW-1:0] s2_dst_i,
  output hz_act_e       act_o
);
  logic match;
  logic in_dev;

  assign match  = s1_vld_i && s2_vld_i && (s1_src_i == s2_dst_i);
  assign in_dev = (s1_src_i >= DEV_BASE);

  always_comb begin
    act_o = HZ_NONE;
    if (match) act_o = in_dev ? HZ_STALL : HZ_FWD;
  end
endmodule

// File: rtl/mvh_opstore.sv
module mvh_opstore
  import mvh_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hz_act_e       act_i,
  input  logic          s1_vld_i,
  input  logic [AW-1:0] s1_dst_i,
  input  logic [DW-1:0] rdata_i,
  output logic          s2_vld_o,
  output logic [AW-1:0] s2_dst_o,
  output logic [DW-1:0] s2_op_o
);
  logic [DW-1:0] op_sel;

  assign op_sel = (act_i == HZ_FWD) ? s2_op_o : rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_o <= 1'b0;
      s2_dst_o <= '0;
      s2_op_o  <= '0;
    end else if (act_i == HZ_STALL) begin
      s2_vld_o <= 1'b0;  // bubble: store suppressed
    end else begin
      s2_vld_o <= s1_vld_i;
      s2_dst_o <= s1_dst_i;
      s2_op_o  <= op_sel;
    end
  end
endmodule

// File: rtl/mv_pipe_hazard.sv
module mv_pipe_hazard
  import mvh_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 16,
  parameter logic [AW-1:0] DEV_BASE = 16'hFF00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] if_addr0_o,
  output logic [AW-1:0] if_addr1_o,
  input  logic          if_vld_i,
  input  logic [AW-1:0] if_word0_i,
  input  logic [AW-1:0] if_word1_i,
  output logic [AW-1:0] of_addr_o,
  input  logic [DW-1:0] of_rdata_i,
  output logic [AW-1:0] st_addr_o,
  output logic [DW-1:0] st_wdata_o,
  output logic          st_we_o,
  output logic          fwd_o,
  output logic          ilk_o
);
  localparam logic [AW-1:0] WORD1_OFS = AW'(1);

  hz_act_e       act;
  logic [AW-1:0] pc;
  logic          s1_vld;
  logic [AW-1:0] s1_src;
  logic [AW-1:0] s1_dst;
  logic          s2_vld;
  logic [AW-1:0] s2_dst;
  logic [DW-1:0] s2_op;

  mvh_fetch #(.AW(AW)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (act == HZ_STALL),
    .vld_i    (if_vld_i),
    .word0_i  (if_word0_i),
    .word1_i  (if_word1_i),
    .pc_o     (pc),
    .s1_vld_o (s1_vld),
    .s1_src_o (s1_src),
    .s1_dst_o (s1_dst)
  );

  mvh_hazard #(.AW(AW), .DEV_BASE(DEV_BASE)) u_hazard (
    .s1_vld_i (s1_vld),
    .s1_src_i (s1_src),
    .s2_vld_i (s2_vld),
    .s2_dst_i (s2_dst),
    .act_o    (act)
  );

  mvh_opstore #(.AW(AW), .DW(DW)) u_opstore (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act),
    .s1_vld_i (s1_vld),
    .s1_dst_i (s1_dst),
    .rdata_i  (of_rdata_i),
    .s2_vld_o (s2_vld),
    .s2_dst_o (s2_dst),
    .s2_op_o  (s2_op)
  );

  assign if_addr0_o = pc;
  assign if_addr1_o = pc + WORD1_OFS;
  assign of_addr_o  = s1_src;
  assign st_addr_o  = s2_dst;
  assign st_wdata_o = s2_op;
  assign st_we_o    = s2_vld;
  assign fwd_o      = (act == HZ_FWD);
  assign ilk_o      = (act == HZ_STALL);
endmodule

// File: rtl/mvh_checker.sv
module mvh_checker #(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 16,
  parameter logic [AW-1:0] DEV_BASE = 16'hFF00
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] if_addr0_o,
  input logic [AW-1:0] if_addr1_o,
  input logic          if_vld_i,
  input logic [AW-1:0] if_word0_i,
  input logic [AW-1:0] if_word1_i,
  input logic [AW-1:0] of_addr_o,
  input logic [DW-1:0] of_rdata_i,
  input logic [AW-1:0] st_addr_o,
  input logic [DW-1:0] st_wdata_o,
  input logic          st_we_o,
  input logic          fwd_o,
  input logic          ilk_o
);
  p_fetch_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_addr1_o == if_addr0_o + AW'(1));

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (if_addr0_o == $past(if_addr0_o)) || (if_addr0_o == $past(if_addr0_o) + AW'(2)));

  p_fetch_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_vld_i |=> $stable(if_addr0_o));

  p_fwd_mem_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> st_we_o && (of_addr_o == st_addr_o) && (of_addr_o < DEV_BASE));

  p_fwd_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |=> st_we_o && (st_wdata_o == $past(st_wdata_o)));

  p_ilk_dev_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilk_o |-> st_we_o && (of_addr_o == st_addr_o) && (of_addr_o >= DEV_BASE));

  p_ilk_bubble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilk_o |=> !st_we_o);

  p_ilk_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilk_o |=> $stable(of_addr_o) && $stable(if_addr0_o));

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fwd_o && ilk_o));
endmodule

bind mv_pipe_hazard mvh_checker #(.AW(AW), .DW(DW), .DEV_BASE(DEV_BASE)) u_chk (.*);

// File: tb/mv_pipe_hazard_test.sv
`timescale 1ns/1ps
module mv_pipe_hazard_test;
  localparam logic [15:0] DEV = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] if_addr0, if_addr1, if_w0, if_w1, of_addr, of_rdata, st_addr, st_wdata;
  logic        if_vld, st_we, fwd, ilk;

  always #2 clk = ~clk;

  mv_pipe_hazard uut (
    .clk_i(clk), .rst_ni(rst_n),
    .if_addr0_o(if_addr0), .if_addr1_o(if_addr1),
    .if_vld_i(if_vld), .if_word0_i(if_w0), .if_word1_i(if_w1),
    .of_addr_o(of_addr), .of_rdata_i(of_rdata),
    .st_addr_o(st_addr), .st_wdata_o(st_wdata), .st_we_o(st_we),
    .fwd_o(fwd), .ilk_o(ilk)
  );

  typedef struct { logic [15:0] a; logic [15:0] d; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  int fwd_cnt = 0, ilk_cnt = 0, excl_cnt = 0, st_cnt = 0;
  int ref_fwd = 0, ref_ilk = 0;
  string cur_tag = "R3";
  logic [15:0] exp_pc = 16'h0;
  logic [15:0] prev_dst = 16'h0;
  bit prev_ok = 1'b0;
  bit prev_ilk = 1'b0;

  logic [15:0] mdl_mem [logic [15:0]];
  logic [15:0] ref_mem [logic [15:0]];

  function automatic logic [15:0] seed(input logic [15:0] a);
    return (a >= DEV) ? (a & 16'h00FF) : (a ^ 16'h3C3C);
  endfunction

  // device locations: write adds into an accumulator, read returns it
  function automatic logic [15:0] mdl_rd(input logic [15:0] a);
    return mdl_mem.exists(a) ? mdl_mem[a] : seed(a);
  endfunction
  function automatic void mdl_wr(input logic [15:0] a, input logic [15:0] d);
    mdl_mem[a] = (a >= DEV) ? mdl_rd(a) + d : d;
  endfunction
  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : seed(a);
  endfunction
  function automatic void ref_wr(input logic [15:0] a, input logic [15:0] d);
    ref_mem[a] = (a >= DEV) ? ref_rd(a) + d : d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and monitor
  initial begin
    forever begin
      @(negedge clk);
      of_rdata = mdl_rd(of_addr);
      if (fwd) fwd_cnt++;
      if (ilk) ilk_cnt++;
      if (fwd && ilk) excl_cnt++;
      if (rst_n && prev_ilk)
        check(!st_we, "R6", "store after interlock", 32'(st_we), 32'h0);
      if (rst_n && fwd)
        check(of_addr == st_addr && st_we, "R5", "forward address match", 32'(of_addr), 32'(st_addr));
      if (rst_n && st_we) begin
        st_cnt++;
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected store", 32'(st_addr), 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(st_addr == e.a && st_wdata == e.d, cur_tag, "store {addr,data}",
                {st_addr, st_wdata}, {e.a, e.d});
        end
        mdl_wr(st_addr, st_wdata);
      end
      prev_ilk = rst_n && ilk;
    end
  end

  task automatic issue(input logic [15:0] src, input logic [15:0] dst, input int gap);
    exp_t e;
    bit haz;
    repeat (gap) begin if_vld = 1'b0; @(negedge clk); end
    if_vld = 1'b1; if_w0 = src; if_w1 = dst;
    check(if_addr0 == exp_pc && if_addr1 == exp_pc + 16'd1, "R2", "fetch address pair",
          {if_addr0, if_addr1}, {exp_pc, exp_pc + 16'd1});
    while (ilk) @(negedge clk);
    haz = (gap == 0) && prev_ok && (src == prev_dst);
    if (haz) begin
      if (src >= DEV) ref_ilk++; else ref_fwd++;
    end
    prev_ok = 1'b1; prev_dst = dst;
    e.a = dst; e.d = ref_rd(src);
    ref_wr(dst, e.d);
    q.push_back(e);
    @(negedge clk);
    exp_pc = exp_pc + 16'd2;
    if_vld = 1'b0;
  endtask

  task automatic drain_and_count(input string req);
    if_vld = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    prev_ok = 1'b0;
    check(fwd_cnt == ref_fwd, req, "forward count", 32'(fwd_cnt), 32'(ref_fwd));
    check(ilk_cnt == ref_ilk, req, "interlock count", 32'(ilk_cnt), 32'(ref_ilk));
    fwd_cnt = 0; ilk_cnt = 0; ref_fwd = 0; ref_ilk = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog expired: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    if_vld = 1'b0; if_w0 = '0; if_w1 = '0; of_rdata = '0;
    repeat (3) @(negedge clk);
    check(if_addr0 == 16'h0 && if_addr1 == 16'h1, "R1", "fetch addr in reset",
          {if_addr0, if_addr1}, 32'h0000_0001);
    check(!st_we && !fwd && !ilk, "R1", "we/fwd/ilk in reset", {st_we, fwd, ilk}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(if_addr0 == 16'h0 && !st_we && !fwd && !ilk, "R1", "state after release",
          {if_addr0, 13'h0, st_we, fwd, ilk}, 32'h0);

    // R3: independent moves
    cur_tag = "R3";
    issue(16'h0100, 16'h0200, 0);
    issue(16'h0101, 16'h0201, 0);
    issue(16'h0102, 16'h0202, 0);
    issue(16'h0200, 16'h0203, 0);
    issue(16'h0203, 16'h0204, 1);
    drain_and_count("R3");

    // R5: forwarding chains in ordinary memory, incl. last address below region
    cur_tag = "R5";
    issue(16'h0110, 16'h0120, 0);
    issue(16'h0120, 16'h0121, 0);
    issue(16'h0121, 16'h0122, 0);
    issue(16'h0122, 16'h0110, 0);
    issue(16'h0130, 16'hFEFF, 0);
    issue(16'hFEFF, 16'h0131, 0);
    drain_and_count("R5");

    // R6: interlocks on device locations, incl. region base and top
    cur_tag = "R6";
    issue(16'h0140, 16'hFF00, 0);
    issue(16'hFF00, 16'h0141, 0);
    issue(16'h0141, 16'hFF00, 0);
    issue(16'hFF00, 16'hFF00, 0);
    issue(16'hFF00, 16'h0142, 0);
    issue(16'h0143, 16'hFFFF, 0);
    issue(16'hFFFF, 16'h0144, 0);
    drain_and_count("R6");

    // R4: dependencies broken by bubbles, near misses, distance two
    cur_tag = "R4";
    issue(16'h0150, 16'h0151, 0);
    issue(16'h0151, 16'h0152, 1);
    issue(16'h0154, 16'hFF00, 0);
    issue(16'hFF00, 16'h0155, 1);
    issue(16'h0156, 16'h0157, 0);
    issue(16'h0158, 16'h0159, 0);
    issue(16'h0160, 16'h0161, 0);
    issue(16'h0170, 16'h0171, 0);
    issue(16'h0161, 16'h0162, 0);
    drain_and_count("R4");

    // R7: forwarding and interlocks interleaved
    cur_tag = "R7";
    issue(16'h0180, 16'hFF20, 0);
    issue(16'hFF20, 16'h0181, 0);
    issue(16'h0181, 16'h0182, 0);
    issue(16'h0182, 16'hFF20, 0);
    issue(16'hFF20, 16'h0183, 0);
    drain_and_count("R7");
    check(excl_cnt == 0, "R7", "cycles with fwd and ilk both high", 32'(excl_cnt), 32'h0);

    // R8: idle fetch produces no store and no fetch advance
    cur_tag = "R8";
    st_cnt = 0;
    if_vld = 1'b0;
    repeat (12) @(negedge clk);
    check(st_cnt == 0, "R8", "stores while idle", 32'(st_cnt), 32'h0);
    check(if_addr0 == exp_pc, "R2", "fetch addr held while idle", 32'(if_addr0), 32'(exp_pc));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule